// File: doc/BRIEF.md
# Pulse-Swallow Programmable Frequency Divider

This block is the feedback divider of an integer-N frequency synthesizer. It runs at the oscillator rate. A dual-modulus prescaler with a fixed base modulus of 16 is steered by a swallow counter and a main counter. The prescaler divides by 17 while swallow pulses remain in the current cycle and by 16 after that. The main counter counts prescaler periods. One output pulse is issued every 16·B + A input clocks.

The ratio is programmed through a 24-bit register image that arrives as three bytes, most significant byte first. The image is evaluated only when its third byte arrives. A commit whose register-select code does not address this divider is ignored. A commit that carries an illegal ratio raises a sticky error flag and leaves the ratio in use unchanged. A legal new ratio is applied only at the boundary between two division cycles.

Top module: `swallow_div`

## Requirements
- R1: With swallow value A and main value B in force, successive `div_o` pulses are exactly 16·B + A input clocks apart.
- R2: `div_o` is high for exactly one clock per division cycle.
- R3: After reset is released, the first `div_o` pulse appears on the (16·DEF_B + DEF_A)-th rising clock edge. The defaults are DEF_B = 4 and DEF_A = 3, which gives 67.
- R4: Bytes written on `byte_i` while `byte_valid_i` is high are shifted in most significant byte first. The 24-bit image is evaluated on the clock of the third byte. In the image, A is bits 8:2, B is bits 19:9, and the select code is bits 1:0. Bits 23:20 have no effect.
- R5: A ratio committed in the middle of a division cycle leaves the length of that cycle unchanged. The new ratio governs the next full cycle.
- R6: A committed image addressed to this divider with B < 2, A > 15, or A ≥ B sets `cfg_err_o`. The flag stays high until reset. The ratio in use is kept.
- R7: A committed image whose bits 1:0 are not 2'b01 changes neither the ratio nor `cfg_err_o`.
- R8: During reset, `div_o` and `cfg_err_o` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Oscillator-rate input clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| byte_valid_i | input | 1 | Qualifies `byte_i` for one clock |
| byte_i | input | 8 | Register image byte, most significant byte first |
| div_o | output | 1 | One-clock pulse per division cycle |
| cfg_err_o | output | 1 | Sticky flag for a rejected ratio |

## Verification
The final byte is registered on its rising edge. The new ratio is therefore held from that edge on, and `cfg_err_o` is visible from the same edge. The ratio first shapes the cycle that begins after the next `div_o` pulse. `div_o` rises on the N-th edge of its cycle. The bench keeps a per-clock behavioural model that applies the same timing. The model reloads its period from the ratio held before the edge and updates the staged ratio after that, and it is compared with both outputs at every falling edge. The bench also counts falling edges between pulses, adding the three write clocks, so that the interval that spans a write and the following full interval are checked against 16·B + A.

// File: rtl/swallow_pkg.sv
package swallow_pkg;
  localparam int PSC_MOD  = 16;
  localparam int IMG_W    = 24;
  localparam int A_LSB    = 2;
  localparam int A_W      = 7;
  localparam int B_LSB    = 9;
  localparam int B_W      = 11;
  localparam logic [1:0] SEL_MAIN = 2'b01;

  typedef struct packed {
    logic [B_W-1:0] b;
    logic [A_W-1:0] a;
  } ratio_t;
endpackage

// File: rtl/swallow_cfg.sv
module swallow_cfg
  import swallow_pkg::*;
#(
  parameter int DEF_A = 3,
  parameter int DEF_B = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       byte_valid_i,
  input  logic [7:0] byte_i,
  output ratio_t     ratio_o,
  output logic       err_o
);
  localparam logic [A_W-1:0] A_MAX = A_W'(PSC_MOD - 1);
  localparam logic [B_W-1:0] B_MIN = B_W'(2);

  logic [15:0]      head_q;
  logic [1:0]       cnt_q;
  logic [IMG_W-1:0] full;
  logic             commit, sel_ok, bad;
  ratio_t           nxt;

  assign full   = {head_q, byte_i};
  assign commit = byte_valid_i && (cnt_q == 2'd2);
  assign sel_ok = full[1:0] == SEL_MAIN;
  assign nxt.a  = full[A_LSB +: A_W];
  assign nxt.b  = full[B_LSB +: B_W];
  assign bad    = (nxt.b < B_MIN) || (nxt.a > A_MAX) ||
                  ({{(B_W-A_W){1'b0}}, nxt.a} >= nxt.b);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q  <= '0;
      cnt_q   <= '0;
      ratio_o <= '{b: B_W'(DEF_B), a: A_W'(DEF_A)};
      err_o   <= 1'b0;
    end else if (byte_valid_i) begin
      if (commit) begin
        cnt_q <= '0;
        if (sel_ok) begin
          if (bad) err_o   <= 1'b1;
          else     ratio_o <= nxt;
        end
      end else begin
        head_q <= {head_q[7:0], byte_i};
        cnt_q  <= cnt_q + 2'd1;
      end
    end
  end

  // R6
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);
  // R6
  ratio_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ratio_o.b >= B_MIN) && (ratio_o.a <= A_MAX) &&
    ({{(B_W-A_W){1'b0}}, ratio_o.a} < ratio_o.b));
  // R4
  ratio_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit |=> $stable(ratio_o));
endmodule

// File: rtl/swallow_core.sv
module swallow_core
  import swallow_pkg::*;
#(
  parameter int DEF_A = 3,
  parameter int DEF_B = 4
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  ratio_t ratio_i,
  output logic   div_o
);
  localparam int PW = $clog2(PSC_MOD + 1);
  localparam int AW = $clog2(PSC_MOD);

  logic [PW-1:0]  psc_q;
  logic [AW-1:0]  a_left_q;
  logic [B_W-1:0] b_left_q;
  logic           psc_tc, cyc_end;

  // Modulus 17 while swallows remain, 16 afterwards
  assign psc_tc  = psc_q == ((a_left_q != '0) ? PW'(PSC_MOD) : PW'(PSC_MOD - 1));
  assign cyc_end = psc_tc && (b_left_q == B_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      psc_q    <= '0;
      a_left_q <= AW'(DEF_A);
      b_left_q <= B_W'(DEF_B);
      div_o    <= 1'b0;
    end else begin
      div_o <= cyc_end;
      if (psc_tc) begin
        psc_q <= '0;
        if (cyc_end) begin
          a_left_q <= ratio_i.a[AW-1:0];
          b_left_q <= ratio_i.b;
        end else begin
          b_left_q <= b_left_q - B_W'(1);
          if (a_left_q != '0) a_left_q <= a_left_q - AW'(1);
        end
      end else begin
        psc_q <= psc_q + PW'(1);
      end
    end
  end

  // R2
  pulse_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_o |=> !div_o);
  // R1
  psc_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    psc_q <= PW'(PSC_MOD));
  // R5
  main_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !psc_tc |=> $stable(b_left_q) && $stable(a_left_q));
  // R1
  main_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    b_left_q != '0);
endmodule

// File: rtl/swallow_div.sv
module swallow_div
  import swallow_pkg::*;
#(
  parameter int DEF_A = 3,
  parameter int DEF_B = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       byte_valid_i,
  input  logic [7:0] byte_i,
  output logic       div_o,
  output logic       cfg_err_o
);
  ratio_t ratio;

  swallow_cfg #(.DEF_A(DEF_A), .DEF_B(DEF_B)) u_cfg (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .byte_valid_i (byte_valid_i),
    .byte_i       (byte_i),
    .ratio_o      (ratio),
    .err_o        (cfg_err_o)
  );

  swallow_core #(.DEF_A(DEF_A), .DEF_B(DEF_B)) u_core (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ratio_i (ratio),
    .div_o   (div_o)
  );
endmodule

// File: tb/swallow_div_tb.sv
module swallow_div_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       byte_valid_i = 1'b0;
  logic [7:0] byte_i = '0;
  logic       div_o, cfg_err_o;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  swallow_div u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .byte_valid_i(byte_valid_i),
    .byte_i(byte_i), .div_o(div_o), .cfg_err_o(cfg_err_o)
  );

  // Behavioural reference model
  int        m_ph, m_n, m_a, m_b, m_nb;
  bit        m_div, m_err;
  bit [23:0] m_img;
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_ph = 0; m_a = 3; m_b = 4; m_n = 67; m_nb = 0;
      m_div = 0; m_err = 0; m_img = '0;
    end else begin
      m_ph++;
      m_div = 0;
      if (m_ph == m_n) begin
        m_div = 1; m_ph = 0; m_n = 16 * m_b + m_a;
      end
      if (byte_valid_i) begin
        m_img = {m_img[15:0], byte_i};
        m_nb++;
        if (m_nb == 3) begin
          int a, b;
          m_nb = 0;
          a = int'(m_img[8:2]);
          b = int'(m_img[19:9]);
          if (m_img[1:0] == 2'b01) begin
            if (b < 2 || a > 15 || a >= b) m_err = 1;
            else begin m_a = a; m_b = b; end
          end
        end
      end
    end
  end

  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      tests++;
      if (div_o !== m_div) begin
        fails++;
        $display("FAIL R1 R2 div_o actual=%0b expected=%0b", div_o, m_div);
      end
      tests++;
      if (cfg_err_o !== m_err) begin
        fails++;
        $display("FAIL R6 cfg_err_o actual=%0b expected=%0b", cfg_err_o, m_err);
      end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_pulse(output int n);
    n = 0;
    do begin
      @(negedge clk_i);
      n++;
    end while (!div_o);
  endtask

  // Called at the negedge where a pulse was seen; consumes 3 clocks
  task automatic write_img(input bit [1:0] sel, input int a, input int b, input bit [3:0] top);
    bit [23:0] img;
    img = {top, 11'(b), 7'(a), sel};
    for (int i = 2; i >= 0; i--) begin
      byte_valid_i = 1'b1;
      byte_i = img[8*i +: 8];
      @(negedge clk_i);
    end
    byte_valid_i = 1'b0;
    byte_i = '0;
  endtask

  // Write then check the spanning interval and the following one
  task automatic reprogram(input string req, input bit [1:0] sel, input int a, input int b,
                           input int old_n, input int new_n);
    int n;
    write_img(sel, a, b, 4'hA);
    wait_pulse(n);
    check({"R5 spanning ", req}, n + 3, old_n);
    wait_pulse(n);
    check({"R1 ", req}, n, new_n);
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk_i);
    check("R8 div_o in reset", int'(div_o), 0);
    check("R8 cfg_err_o in reset", int'(cfg_err_o), 0);
    rst_ni = 1'b1;
    wait_pulse(n);
    check("R3 first pulse", n, 67);
    wait_pulse(n);
    check("R1 default period", n, 67);
    reprogram("R4 B=2 A=0", 2'b01, 0, 2, 67, 32);
    @(negedge clk_i);
    check("R2 pulse low next clock", int'(div_o), 0);
    wait_pulse(n);
    check("R1 B=2 A=0 repeat", n + 1, 32);
    reprogram("R4 B=2 A=1", 2'b01, 1, 2, 32, 33);
    reprogram("R7 select 10 ignored", 2'b10, 0, 3, 33, 33);
    check("R7 no error", int'(cfg_err_o), 0);
    reprogram("R4 B=16 A=15", 2'b01, 15, 16, 33, 271);
    reprogram("R6 A>=B kept", 2'b01, 2, 2, 271, 271);
    check("R6 err set", int'(cfg_err_o), 1);
    reprogram("R6 B<2 kept", 2'b01, 0, 1, 271, 271);
    reprogram("R6 A>15 kept", 2'b01, 16, 100, 271, 271);
    check("R6 err sticky", int'(cfg_err_o), 1);
    reprogram("R1 B=2047 A=0", 2'b01, 0, 2047, 271, 32752);
    reprogram("R1 B=2047 A=15", 2'b01, 15, 2047, 32752, 32767);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk_i);
    done = 1'b1;
    tests++;
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule